// File: doc/BRIEF.md
# Serial Leading-Ones Counter

This block measures the run of ones at the head of a bit vector that arrives one bit per clock. A data-valid strobe frames the vector. Every cycle in which the strobe is high carries one bit. The block counts consecutive ones from the first framed bit. It stops counting at the first zero, and it ignores every later bit of that vector. When the strobe drops, the vector is complete. The next rising strobe starts a fresh vector with the count at zero.

A build-time option selects how the result appears on the output. In live mode the output is the running count and moves as ones arrive. In hold mode the output keeps the previous vector's final count for the whole time a new vector is being scanned. It takes the new value only once that vector has ended. The count width is derived from the longest vector the block must represent. For the default of 32 bits, every value from 0 to 32 fits.

Top module: `lead_ones_counter`

## Requirements
- R1: A synchronous reset, active high, returns the block to idle and clears the output to 0 on the next rising edge, whatever the strobe and data bit are doing. Reset wins over all other inputs.
- R2: For each rising edge at which the strobe is high and no zero has yet been seen in the current vector, a sampled one adds 1 to the count. With bits 111110000 in arrival order, the final count is 5.
- R3: After the first sampled zero of a vector, further bits of that vector leave the count unchanged.
- R4: While the strobe is low, the data bit has no effect: the count and the output stay unchanged.
- R5: The first framed bit after an idle cycle begins a new vector. The count becomes 1 if that bit is one and 0 if it is zero, and the previous vector's count does not carry over.
- R6: The count never exceeds MAX_LEN. A vector of MAX_LEN ones yields exactly MAX_LEN, and a longer run of ones also yields MAX_LEN.
- R7: With HOLD_RESULT=1, the output stays constant while a vector is being scanned. It takes the vector's final count on the edge that samples the strobe low, so the value is visible one cycle after the last framed bit's edge.
- R8: With HOLD_RESULT=0, the output shows the running count one edge after each framed bit is sampled, and it keeps the final count after the strobe falls until the next vector starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dv_i | input | 1 | Data-valid strobe framing one vector |
| bit_i | input | 1 | Serial data bit, one per framed cycle |
| y_o | output | $clog2(MAX_LEN+1) | Leading-ones count, registered |

## Verification
The bench looks for the cases where a simple counter would go wrong:
- A zero in the first framed bit. A design that started the count at 1 would report 1 instead of 0.
- Ones that come after the first zero. A design that counted every one in the vector would overcount the 101111 pattern.
- Vectors of exactly 32 and 40 ones. These expose a count that wraps to 0 or overflows its width.
- Back-to-back vectors separated by a single idle cycle. These catch a counter that never clears or that carries the old count over.
- Toggling data while the strobe is low. This catches a design that samples the bit without checking the strobe.
- Reset applied mid-vector with the strobe high. This catches reset losing priority.
- Both output variants, checked on every cycle. In hold mode this catches an early or late output update. In live mode it catches a count that lags by a cycle.

// File: rtl/lones_pkg.sv
package lones_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_STOP  = 2'd2
  } lones_state_e;

endpackage

// File: rtl/lones_ctrl.sv
module lones_ctrl
  import lones_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         dv_i,
  input  logic         bit_i,
  output lones_state_e state_q,
  output logic         start_o,
  output logic         advance_o,
  output logic         finish_o
);

  lones_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (dv_i) state_d = bit_i ? ST_COUNT : ST_STOP;
      ST_COUNT: begin
        if (!dv_i)       state_d = ST_IDLE;
        else if (!bit_i) state_d = ST_STOP;
      end
      ST_STOP:  if (!dv_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign start_o   = (state_q == ST_IDLE) && dv_i;
  assign advance_o = (state_q == ST_COUNT) && dv_i && bit_i;
  assign finish_o  = (state_q != ST_IDLE) && !dv_i;

endmodule

// File: rtl/lones_count.sv
module lones_count #(
  parameter int MAX_LEN = 32,
  parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             first_bit_i,
  input  logic             advance_i,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_LEN);

  logic at_cap;
  assign at_cap = (cnt_q >= CNT_CAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(first_bit_i);
    end else if (advance_i && !at_cap) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lones_out.sv
module lones_out #(
  parameter int CNT_W       = 6,
  parameter bit HOLD_RESULT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             finish_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] y_o
);

  generate
    if (HOLD_RESULT) begin : g_hold
      logic [CNT_W-1:0] held_q;
      always_ff @(posedge clk) begin
        if (rst)           held_q <= '0;
        else if (finish_i) held_q <= cnt_i;
      end
      assign y_o = held_q;
    end else begin : g_live
      assign y_o = cnt_i;
    end
  endgenerate

endmodule

// File: rtl/lead_ones_counter.sv
module lead_ones_counter
  import lones_pkg::*;
#(
  parameter int MAX_LEN     = 32,
  parameter bit HOLD_RESULT = 1'b1,
  localparam int CNT_W      = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dv_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] y_o
);

  lones_state_e     state_q;
  logic             start;
  logic             advance;
  logic             finish;
  logic [CNT_W-1:0] cnt_q;

  lones_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .dv_i     (dv_i),
    .bit_i    (bit_i),
    .state_q  (state_q),
    .start_o  (start),
    .advance_o(advance),
    .finish_o (finish)
  );

  lones_count #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .first_bit_i(bit_i),
    .advance_i  (advance),
    .cnt_q      (cnt_q)
  );

  lones_out #(.CNT_W(CNT_W), .HOLD_RESULT(HOLD_RESULT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .finish_i(finish),
    .cnt_i   (cnt_q),
    .y_o     (y_o)
  );

endmodule

// File: rtl/lead_ones_checker.sv
module lead_ones_checker
  import lones_pkg::*;
#(
  parameter int MAX_LEN     = 32,
  parameter bit HOLD_RESULT = 1'b1,
  parameter int CNT_W       = $clog2(MAX_LEN + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             dv_i,
  input logic             bit_i,
  input logic [CNT_W-1:0] y_o,
  input lones_state_e     state_q,
  input logic [CNT_W-1:0] cnt_q
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (y_o == '0)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (y_o <= CNT_W'(MAX_LEN))); // R6

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STOP && dv_i) |=> (cnt_q == $past(cnt_q))); // R3

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!dv_i) |=> $stable(cnt_q)); // R4

  AST_FRESH_START: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && dv_i) |=> (cnt_q == CNT_W'($past(bit_i)))); // R5

  generate
    if (HOLD_RESULT) begin : g_hold_chk
      AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(dv_i)) |-> $stable(y_o)); // R7
    end
  endgenerate

endmodule

bind lead_ones_counter lead_ones_checker #(
  .MAX_LEN    (MAX_LEN),
  .HOLD_RESULT(HOLD_RESULT)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .dv_i   (dv_i),
  .bit_i  (bit_i),
  .y_o    (y_o),
  .state_q(state_q),
  .cnt_q  (cnt_q)
);

// File: tb/lead_ones_counter_bench.sv
module lead_ones_counter_bench;

  localparam int MAXL  = 32;
  localparam int W     = $clog2(MAXL + 1);
  localparam int NV    = 9;

  localparam logic [39:0] VEC [NV] = '{
    40'b111110000,
    40'b0,
    40'b1111,
    40'b01111111,
    40'b101111,
    40'h00FFFFFFFF,
    40'hFFFFFFFFFF,
    40'b111000111111,
    40'b1
  };
  localparam int LEN [NV] = '{9, 1, 4, 8, 6, 32, 40, 12, 1};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dv  = 1'b0;
  logic         x   = 1'b0;
  logic [W-1:0] y_hold;
  logic [W-1:0] y_live;

  int checks = 0;
  int fails  = 0;
  int last_final = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;

  lead_ones_counter #(.MAX_LEN(MAXL), .HOLD_RESULT(1'b1)) u_lead_ones_counter (
    .clk(clk), .rst(rst), .dv_i(dv), .bit_i(x), .y_o(y_hold)
  );

  lead_ones_counter #(.MAX_LEN(MAXL), .HOLD_RESULT(1'b0)) u_lead_ones_counter_live (
    .clk(clk), .rst(rst), .dv_i(dv), .bit_i(x), .y_o(y_live)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Sends one vector, MSB of the used field first, checking every cycle.
  task automatic run_vec(input logic [39:0] v, input int len);
    int  run = 0;
    bit  ones = 1'b1;
    for (int i = len - 1; i >= 0; i--) begin
      dv = 1'b1;
      x  = v[i];
      @(negedge clk);
      if (ones && v[i]) begin
        if (run < MAXL) run++;
      end else begin
        ones = 1'b0;
      end
      check(int'(y_live), run, "R2/R3/R6/R8 live running count");
      check(int'(y_hold), last_final, "R7 hold output stable during scan");
    end
    dv = 1'b0;
    @(negedge clk);
    check(int'(y_hold), run, "R2/R5/R6/R7 hold final count");
    check(int'(y_live), run, "R8 live keeps final count");
    last_final = run;
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(int'(y_hold), 0, "R1 reset state hold");
    check(int'(y_live), 0, "R1 reset state live");
    rst = 1'b0;

    // Table of vectors, back to back with one idle cycle between them
    for (int k = 0; k < NV; k++) run_vec(VEC[k], LEN[k]);

    // R4: data toggling with strobe low has no effect
    for (int i = 0; i < 6; i++) begin
      x = ~x;
      @(negedge clk);
      check(int'(y_hold), last_final, "R4 hold ignores bits while idle");
      check(int'(y_live), last_final, "R4 live ignores bits while idle");
    end

    // R1: reset mid-vector with strobe and data high
    dv = 1'b1; x = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(int'(y_hold), 0, "R1 reset priority hold");
    check(int'(y_live), 0, "R1 reset priority live");
    rst = 1'b0; dv = 1'b0;
    @(negedge clk);
    check(int'(y_hold), 0, "R1 after reset hold");
    check(int'(y_live), 0, "R1 after reset live");
    last_final = 0;

    // R5: fresh vector after reset
    run_vec(40'b110, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule